// File: doc/BRIEF.md
# Switch-Selected Asymmetric Differential Clock Generator

This block produces a free-running, fixed-frequency clock for a two-wire differential network link. It runs from a 64 MHz timebase, which gives 15.625 ns per tick. Each period starts with a short high pulse, the mark, followed by a longer low stretch, so the waveform is asymmetric. The block drives two outputs: a true clock and its exact logical complement. Both come from registers that switch on the same clock edge, so no external line driver is needed to form the differential pair.

A 4-bit switch bank selects one of eight period/mark settings, with periods from 5 µs down to 2 µs. The bank is synchronised inside the block. Its upper three bits form the preset number and its lowest bit is ignored. A new setting is adopted only when the running period wraps. The period in progress is therefore never shortened, and no runt pulse can appear.

Top module: `diffclk_gen`

## Requirements
- R1: While `rst_n` is low at a rising edge of `clk`, the next edge leaves `clk_p` = 0 and `clk_n` = 1.
- R2: The period in ticks for preset number 0..7 is 320, 256, 256, 192, 192, 128, 128, 128.
- R3: Each period begins with `clk_p` high for the mark, in ticks 64, 48, 32, 32, 16, 32, 16, 8 for presets 0..7, and `clk_p` is low for the rest of the period.
- R4: The preset number is `sw[3:1]`, with `sw[3]` as its most significant bit.
- R5: `sw[0]` has no effect on period or mark, even when it toggles in the middle of a period.
- R6: Out of reset, `clk_n` is always the logical inverse of `clk_p`, with no cycle of skew.
- R7: A switch change in the middle of a period leaves that period's length and mark unchanged. The new preset governs the first period that starts after the synchronised value is seen at a wrap.
- R8: After reset is released, `clk_p` rises on the first clock edge, and the first period uses preset 0 whatever the switches read.
- R9: The internal tick counter stays below the active period, and the active preset changes only on the cycle the counter wraps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 64 MHz timebase |
| rst_n | input | 1 | Synchronous active-low reset |
| sw | input | 4 | Asynchronous switch bank; bit 3 is the left-most switch |
| clk_p | output | 1 | True (non-inverted) network clock |
| clk_n | output | 1 | Complement of `clk_p` |

## Verification
The counter wrap and the loading of a new preset share a cycle. A switch change that reaches the synchroniser output close to that wrap decides whether the next period uses the old setting or the new one. The bench changes the switches at fixed offsets inside a running period, then measures that period and the one after it in ticks. It judges that the first period keeps the old length and mark and the second carries the new setting. It also toggles only `sw[0]` in the same way and expects both periods to be unchanged.

// File: rtl/diffclk_pkg.sv
// Package: shared tick type, preset record and the preset lookup.
// Assumes a 64 MHz timebase, so one tick is 15.625 ns.
package diffclk_pkg;
    localparam int TICK_W = 9;                 // holds the longest period, 320
    localparam int SW_W   = 4;                 // switch bank width
    localparam int SEL_W  = 3;                 // decoded upper switch bits

    typedef logic [TICK_W-1:0] tick_t;

    typedef struct packed {
        tick_t period;
        tick_t mark;
    } preset_t;

    // Returns period and mark in ticks for a preset number.
    function automatic preset_t preset_lookup(input logic [SEL_W-1:0] sel);
        preset_t p;
        case (sel)
            3'd0:    begin p.period = tick_t'(320); p.mark = tick_t'(64); end
            3'd1:    begin p.period = tick_t'(256); p.mark = tick_t'(48); end
            3'd2:    begin p.period = tick_t'(256); p.mark = tick_t'(32); end
            3'd3:    begin p.period = tick_t'(192); p.mark = tick_t'(32); end
            3'd4:    begin p.period = tick_t'(192); p.mark = tick_t'(16); end
            3'd5:    begin p.period = tick_t'(128); p.mark = tick_t'(32); end
            3'd6:    begin p.period = tick_t'(128); p.mark = tick_t'(16); end
            default: begin p.period = tick_t'(128); p.mark = tick_t'(8);  end
        endcase
        return p;
    endfunction
endpackage

// File: rtl/sw_sync.sv
// Module: sw_sync
// Multi-flop synchroniser for a slow, asynchronous switch bus.
// Assumes the switches are quasi-static, so a bit-wise skew of one
// cycle between bits is harmless; STAGES must be at least 2.
module sw_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    // Shift the raw switch value through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/preset_decode.sv
// Module: preset_decode
// Maps the synchronised switch bus to a period/mark pair.
// Assumes the top SEL_W bits form the preset number, with the MSB on the
// left-most switch; the remaining low bit is deliberately unused.
module preset_decode
    import diffclk_pkg::*;
(
    input  logic [SW_W-1:0] sw_q,
    output preset_t         preset
);
    logic [SEL_W-1:0] sel;
    logic             unused_low;

    // Take the preset number from the upper bits only.
    always_comb begin
        sel        = sw_q[SW_W-1 -: SEL_W];
        unused_low = sw_q[0];
        preset     = preset_lookup(sel);
    end
endmodule

// File: rtl/period_engine.sv
// Module: period_engine
// Period counter, mark comparison and the complementary output registers.
// Assumes next_preset is already synchronous to clk. It is sampled only on
// the wrap cycle, so a period is never cut short or stretched.
module period_engine
    import diffclk_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  preset_t next_preset,
    output logic    clk_p,
    output logic    clk_n
);
    tick_t   cnt;
    preset_t act;
    logic    wrap;
    logic    in_mark;

    // Flag the last tick of the period and the mark window.
    always_comb begin
        wrap    = (cnt == act.period - tick_t'(1));
        in_mark = (cnt < act.mark);
    end

    // Advance the counter and adopt a new preset at the boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            act <= preset_lookup('0);
        end else if (wrap) begin
            cnt <= '0;
            act <= next_preset;
        end else begin
            cnt <= cnt + tick_t'(1);
        end
    end

    // Register both output polarities on the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_p <= 1'b0;
            clk_n <= 1'b1;
        end else begin
            clk_p <= in_mark;
            clk_n <= !in_mark;
        end
    end

    // R9: counter never reaches the active period
    p_cnt_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < act.period);

    // R9: active preset only moves on a wrap
    p_preset_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(act));

    // R3: a period start is followed by a high true output
    p_mark_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0) |=> clk_p);
endmodule

// File: rtl/diffclk_gen.sv
// Module: diffclk_gen
// Switch-selected asymmetric differential clock generator (top level).
// Assumes clk is the 64 MHz timebase and sw is asynchronous to it.
module diffclk_gen
    import diffclk_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [SW_W-1:0] sw,
    output logic            clk_p,
    output logic            clk_n
);
    logic [SW_W-1:0] sw_q;
    preset_t         next_preset;

    sw_sync #(.W(SW_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (sw),
        .q     (sw_q)
    );

    preset_decode u_decode (
        .sw_q   (sw_q),
        .preset (next_preset)
    );

    period_engine u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .next_preset (next_preset),
        .clk_p       (clk_p),
        .clk_n       (clk_n)
    );

    // R1: reset forces true low, inverted high
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (!clk_p && clk_n));

    // R6: the two outputs are always complementary
    p_complement_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clk_n == !clk_p);

    // R8: output rises on the first edge after reset release
    p_first_rise_r8: assert property (@(posedge clk)
        ($past(!rst_n) && rst_n) |=> clk_p);
endmodule

// File: tb/diffclk_gen_bench.sv
module diffclk_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] sw = 4'b1110;
    logic       clk_p, clk_n;

    int errors = 0;
    int checks = 0;
    int mism   = 0;
    bit mon_en = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    diffclk_gen u_diffclk_gen (
        .clk   (clk),
        .rst_n (rst_n),
        .sw    (sw),
        .clk_p (clk_p),
        .clk_n (clk_n)
    );

    // Stimulus/expectation table: index = sw[3:1], sw[0] varied.
    localparam logic [3:0] T_SW   [8] = '{4'b0000, 4'b0011, 4'b0100, 4'b0111,
                                          4'b1000, 4'b1011, 4'b1100, 4'b1111};
    localparam int         T_PER  [8] = '{320, 256, 256, 192, 192, 128, 128, 128};
    localparam int         T_MARK [8] = '{64, 48, 32, 32, 16, 32, 16, 8};

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Complement monitor (R6), sampled at falling edges.
    always @(negedge clk) begin
        if (mon_en && (clk_n !== ~clk_p)) mism++;
    end

    // Wait for the next rising edge of clk_p, sampled at falling edges.
    task automatic wait_rise();
        logic prev;
        prev = clk_p;
        @(negedge clk);
        while (!(!prev && clk_p)) begin
            prev = clk_p;
            @(negedge clk);
        end
    endtask

    // Measure one full period from the next rise; optionally change sw mid-way.
    task automatic meas(input logic [3:0] mid_sw, input int mid_at,
                        output int per, output int hi);
        logic prev;
        wait_rise();
        per = 0;
        hi  = 0;
        do begin
            if (per == mid_at) sw = mid_sw;
            per++;
            if (clk_p) hi++;
            prev = clk_p;
            @(negedge clk);
        end while (!(!prev && clk_p));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            report();
        end
    end

    initial begin
        int per, hi;
        // R1: reset state with switches set to a non-zero preset
        repeat (4) @(negedge clk);
        chk(clk_p === 1'b0, "R1 clk_p in reset", int'(clk_p), 0);
        chk(clk_n === 1'b1, "R1 clk_n in reset", int'(clk_n), 1);
        mon_en = 1;
        rst_n = 1'b1;
        // R8: first period after release is preset 0 regardless of sw=1110
        meas(4'b1110, -1, per, hi);
        chk(per == 320, "R8 first period", per, 320);
        chk(hi == 64,   "R8 first mark", hi, 64);

        // R2 R3 R4: walk the table
        for (int i = 0; i < 8; i++) begin
            sw = T_SW[i];
            wait_rise();
            wait_rise();
            meas(T_SW[i], -1, per, hi);
            chk(per == T_PER[i],  $sformatf("R2 R4 period sw=%b", T_SW[i]), per, T_PER[i]);
            chk(hi  == T_MARK[i], $sformatf("R3 R4 mark sw=%b", T_SW[i]), hi, T_MARK[i]);
        end

        // R7: mid-period change keeps the running period intact
        sw = 4'b0000;
        wait_rise();
        wait_rise();
        meas(4'b1110, 100, per, hi);
        chk(per == 320, "R7 running period kept", per, 320);
        chk(hi == 64,   "R7 running mark kept", hi, 64);
        meas(4'b1110, -1, per, hi);
        chk(per == 128, "R7 next period adopts", per, 128);
        chk(hi == 8,    "R7 next mark adopts", hi, 8);

        // R7: change just before the wrap of a short period
        meas(4'b0010, 126, per, hi);
        chk(per == 128, "R7 late change period", per, 128);
        chk(hi == 8,    "R7 late change mark", hi, 8);
        wait_rise();
        meas(4'b0010, -1, per, hi);
        chk(per == 256, "R7 late change settled", per, 256);
        chk(hi == 48,   "R7 late change settled mark", hi, 48);

        // R5: toggling only sw[0] has no effect
        sw = 4'b0100;
        wait_rise();
        wait_rise();
        meas(4'b0101, 10, per, hi);
        chk(per == 256, "R5 bit0 toggle period", per, 256);
        chk(hi == 32,   "R5 bit0 toggle mark", hi, 32);
        meas(4'b0100, 20, per, hi);
        chk(per == 256, "R5 bit0 next period", per, 256);
        chk(hi == 32,   "R5 bit0 next mark", hi, 32);

        // R6: outputs stayed complementary throughout
        chk(mism == 0, "R6 complement mismatches", mism, 0);

        // R1: reset asserted mid-run returns outputs to the reset state
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(clk_p === 1'b0, "R1 clk_p after re-reset", int'(clk_p), 0);
        chk(clk_n === 1'b1, "R1 clk_n after re-reset", int'(clk_n), 1);

        done = 1;
        report();
    end
endmodule